// File: doc/BRIEF.md
# Time-Division Multiplexed Serial Transmitter

This block sends CPU-written words onto a single serial line that is shared in time. A frame begins when the frame-sync input is seen with a bit strobe. The frame then holds one slot (single-slot mode) or a programmable run of back-to-back slots (multi-slot mode). In each slot the block either shifts out one buffered word, most significant bit first, or leaves the line undriven. It drives the line for a slot only when it sends data. An external pad buffer uses the enable output to tri-state the line.

Software sees a one-word holding buffer with two write strobes. The data strobe queues a word for transmission. The idle strobe reserves the next slot as silent. Either write marks the buffer full. At the start of every slot the buffer content moves into the shift register, and the buffer-empty flag rises again. A slot-zero flag tells software that the frame's first slot is in progress. The word written at that moment lands in slot one in multi-slot mode, or in the next frame's slot zero in single-slot mode. If no write arrived in time, the slot is flagged as an underrun and stays silent. An interrupt request follows the buffer-empty flag when it is enabled.

All logic runs on the system clock. The serial bit rate is given by a one-cycle bit strobe.

Top module: `tdm_tx`

## Requirements
- R1: After a synchronous active-low reset, tbe is 1, tfs is 0, underflow is 0, sd_oe is 0 and irq is 0 while irq_en is 0.
- R2: A data slot drives sd_oe high and puts one bit per bit strobe on sd_out, most significant bit first. It sends 16 bits when cfg_wlen16 is 1. When cfg_wlen16 is 0 it sends 8 bits, taken from wdata[7:0], and wdata[15:8] is ignored. Each output bit appears in the clock cycle after the strobe that launches it.
- R3: A bit strobe with fsync high starts slot 0. In multi-slot mode (cfg_network=1), cfg_slots_m1+1 slots follow back to back. In single-slot mode there is one slot per frame. sd_oe is 0 outside a slot.
- R4: A write through wr_data or wr_idle clears tbe on the next cycle. The move of the buffer into the shift register at each slot start sets tbe again.
- R5: A word written during slot k of a frame is sent in slot k+1 in multi-slot mode. In single-slot mode it is sent in slot 0 of the next frame. Words go out in the order written.
- R6: tfs is 1 for the whole of slot 0 and goes to 0 at the start of slot 1. It changes only at slot starts.
- R7: A wr_idle write fills the buffer like a data write, but the slot that consumes it keeps sd_oe at 0 for all of its bits. underflow stays 0 for that slot.
- R8: If the buffer is empty when a slot starts, underflow is 1 for that slot and sd_oe stays 0 for all of its bits.
- R9: irq is 1 exactly when tbe is 1 and irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per serial bit period |
| fsync | input | 1 | Frame sync; sampled only with bit_en |
| cfg_network | input | 1 | 1 = multi-slot frames, 0 = one slot per frame |
| cfg_wlen16 | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| cfg_slots_m1 | input | 4 | Slots per frame minus one (multi-slot mode) |
| irq_en | input | 1 | Transmit interrupt enable |
| wr_data | input | 1 | Write strobe for the data buffer |
| wr_idle | input | 1 | Write strobe for the silent-slot register |
| wdata | input | 16 | Write data |
| sd_out | output | 1 | Serial data (0 when not driven) |
| sd_oe | output | 1 | Output enable for the serial pad |
| tfs | output | 1 | Slot-zero flag |
| tbe | output | 1 | Buffer-empty flag |
| underflow | output | 1 | Current slot started with an empty buffer |
| irq | output | 1 | Transmit interrupt request |

## Verification
The scoreboard records, for every slot, whether it should carry data, stay silent by request, or underrun. It then compares the rebuilt serial word and the enable pattern. A design that moved a word one slot too early or too late would show every word shifted in the queue. A design that counted the bit window wrong would show a wrong data length or a drive in the gap after the last slot. The upper byte of an 8-bit write carries junk, so a design that took the wrong byte fails at once. Silent slots and underrun slots are mixed on purpose: a design that treated them alike would either raise underflow for a requested idle or drive the line in an underrun slot. A full 16-slot frame exercises the slot counter wrap and the tfs hand-off.

// File: rtl/tdm_tx_pkg.sv
// Shared types for the TDM transmitter.
package tdm_tx_pkg;
    // Content of the holding buffer: empty, a word to send, or a silent slot.
    typedef enum logic [1:0] {
        SK_NONE = 2'd0,
        SK_DATA = 2'd1,
        SK_IDLE = 2'd2
    } slot_kind_t;
endpackage

// File: rtl/tdm_tx_buffer.sv
// One-entry holding buffer between the CPU writes and the shift register.
// It assumes wr_data and wr_idle are never asserted together.
// A write in the same cycle as a transfer wins: the shifter takes the old
// content and the new write is kept.
module tdm_tx_buffer
    import tdm_tx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic          wr_idle,
    input  logic [DW-1:0] wdata,
    input  logic          xfer,
    output logic [DW-1:0] buf_word,
    output slot_kind_t    buf_kind,
    output logic          tbe
);

    // Track the buffer content and the word stored in it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_kind <= SK_NONE;
            buf_word <= '0;
        end else if (wr_data) begin
            buf_kind <= SK_DATA;
            buf_word <= wdata;
        end else if (wr_idle) begin
            buf_kind <= SK_IDLE;
        end else if (xfer) begin
            buf_kind <= SK_NONE;
        end
    end

    assign tbe = (buf_kind == SK_NONE);

    AST_XFER_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && !wr_data && !wr_idle |=> tbe); // R4

endmodule

// File: rtl/tdm_tx_timing.sv
// Bit and slot sequencer. It works from the bit strobe and the frame sync.
// It assumes fsync is meaningful only together with bit_en.
// A frame sync always restarts slot 0, even in the middle of a word.
module tdm_tx_timing #(
    parameter int DW        = 16,
    parameter int MAX_SLOTS = 16,
    localparam int SW       = $clog2(MAX_SLOTS),
    localparam int CW       = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          fsync,
    input  logic          network,
    input  logic          wlen16,
    input  logic [SW-1:0] slots_m1,
    output logic          slot_start,
    output logic          slot_first,
    output logic          shift_en,
    output logic          slot_stop,
    output logic          in_slot
);

    logic [CW-1:0] bit_cnt;
    logic [SW-1:0] slot_idx;
    logic [CW-1:0] wlen;
    logic          word_done;
    logic          more_slots;

    assign wlen       = wlen16 ? CW'(DW) : CW'(DW / 2);
    assign word_done  = in_slot && (bit_cnt == wlen);
    assign more_slots = network && (slot_idx < slots_m1);

    // Decode the slot events for this bit strobe.
    always_comb begin
        slot_first = bit_en && fsync;
        slot_start = bit_en && (fsync || (word_done && more_slots));
        shift_en   = bit_en && !fsync && in_slot && (bit_cnt < wlen);
        slot_stop  = bit_en && !fsync && word_done && !more_slots;
    end

    // Advance the bit count, the slot index and the in-slot flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            slot_idx <= '0;
            in_slot  <= 1'b0;
        end else if (slot_start) begin
            bit_cnt  <= CW'(1);
            slot_idx <= slot_first ? '0 : slot_idx + 1'b1;
            in_slot  <= 1'b1;
        end else if (shift_en) begin
            bit_cnt  <= bit_cnt + 1'b1;
        end else if (slot_stop) begin
            bit_cnt  <= '0;
            in_slot  <= 1'b0;
        end
    end

    AST_BIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot |-> (bit_cnt != 0) && (bit_cnt <= wlen)); // R2
    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot && !network |-> slot_idx == 0); // R3

endmodule

// File: rtl/tdm_tx_shifter.sv
// Transmit shift register and pad enable.
// At each slot start it loads the buffered word, left-aligned, from the
// buffer content. It drives only for data slots. Data goes out MSB first.
module tdm_tx_shifter
    import tdm_tx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_start,
    input  logic          shift_en,
    input  logic          slot_stop,
    input  logic          wlen16,
    input  slot_kind_t    buf_kind,
    input  logic [DW-1:0] buf_word,
    output logic          sd_out,
    output logic          sd_oe
);

    logic [DW-1:0] shreg;

    // Load at slot start, shift per bit, release the pad at the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            sd_oe <= 1'b0;
        end else if (slot_start) begin
            sd_oe <= (buf_kind == SK_DATA);
            shreg <= wlen16 ? buf_word
                            : {buf_word[DW/2-1:0], {(DW/2){1'b0}}};
        end else if (shift_en) begin
            shreg <= {shreg[DW-2:0], 1'b0};
        end else if (slot_stop) begin
            sd_oe <= 1'b0;
        end
    end

    assign sd_out = sd_oe & shreg[DW-1];

    AST_SILENT_UNLESS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start && (buf_kind != SK_DATA) |=> !sd_oe); // R7

endmodule

// File: rtl/tdm_tx.sv
// TDM serial transmitter top. It connects the holding buffer, the slot
// sequencer and the shifter, and keeps the slot-zero, underrun and
// interrupt outputs. All inputs are synchronous to clk. The configuration
// is assumed stable while a frame is in progress.
module tdm_tx
    import tdm_tx_pkg::*;
#(
    parameter int DW        = 16,
    parameter int MAX_SLOTS = 16,
    localparam int SW       = $clog2(MAX_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          fsync,
    input  logic          cfg_network,
    input  logic          cfg_wlen16,
    input  logic [SW-1:0] cfg_slots_m1,
    input  logic          irq_en,
    input  logic          wr_data,
    input  logic          wr_idle,
    input  logic [DW-1:0] wdata,
    output logic          sd_out,
    output logic          sd_oe,
    output logic          tfs,
    output logic          tbe,
    output logic          underflow,
    output logic          irq
);

    logic          slot_start;
    logic          slot_first;
    logic          shift_en;
    logic          slot_stop;
    logic          in_slot;
    logic [DW-1:0] buf_word;
    slot_kind_t    buf_kind;

    tdm_tx_buffer #(.DW(DW)) u_buffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .wr_idle  (wr_idle),
        .wdata    (wdata),
        .xfer     (slot_start),
        .buf_word (buf_word),
        .buf_kind (buf_kind),
        .tbe      (tbe)
    );

    tdm_tx_timing #(.DW(DW), .MAX_SLOTS(MAX_SLOTS)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .fsync      (fsync),
        .network    (cfg_network),
        .wlen16     (cfg_wlen16),
        .slots_m1   (cfg_slots_m1),
        .slot_start (slot_start),
        .slot_first (slot_first),
        .shift_en   (shift_en),
        .slot_stop  (slot_stop),
        .in_slot    (in_slot)
    );

    tdm_tx_shifter #(.DW(DW)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_start (slot_start),
        .shift_en   (shift_en),
        .slot_stop  (slot_stop),
        .wlen16     (cfg_wlen16),
        .buf_kind   (buf_kind),
        .buf_word   (buf_word),
        .sd_out     (sd_out),
        .sd_oe      (sd_oe)
    );

    // Slot-zero flag: set by the first slot of a frame, cleared by the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tfs <= 1'b0;
        end else if (slot_start) begin
            tfs <= slot_first;
        end
    end

    // Underrun status: latched per slot from the buffer state at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underflow <= 1'b0;
        end else if (slot_start) begin
            underflow <= (buf_kind == SK_NONE);
        end else if (slot_stop) begin
            underflow <= 1'b0;
        end
    end

    assign irq = tbe & irq_en;

    AST_UNDERRUN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> !sd_oe); // R8
    AST_TFS_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start |=> $stable(tfs)); // R6
    AST_DRIVE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> in_slot); // R3

endmodule

// File: tb/tdm_tx_bench.sv
// Scoreboard bench for tdm_tx. A feeder task writes one item per slot and
// queues what that slot must carry. The bit driver doubles as the monitor:
// it rebuilds each slot from the pins and compares it with the queue.
module tdm_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_DIV    = 4;
    localparam int GAP_BITS   = 3;

    typedef struct {
        int          kind;   // 0 = nothing written (underrun), 1 = data, 2 = idle
        logic [15:0] word;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        fsync = 1'b0;
    logic        cfg_network = 1'b0;
    logic        cfg_wlen16 = 1'b0;
    logic [3:0]  cfg_slots_m1 = 4'd0;
    logic        irq_en = 1'b0;
    logic        wr_data = 1'b0;
    logic        wr_idle = 1'b0;
    logic [15:0] wdata = 16'd0;
    logic        sd_out, sd_oe, tfs, tbe, underflow, irq;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    item_t exp_q[$];
    item_t plan_q[$];
    event  slot_ev;

    tdm_tx u_tdm_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
        .cfg_network(cfg_network), .cfg_wlen16(cfg_wlen16),
        .cfg_slots_m1(cfg_slots_m1), .irq_en(irq_en),
        .wr_data(wr_data), .wr_idle(wr_idle), .wdata(wdata),
        .sd_out(sd_out), .sd_oe(sd_oe), .tfs(tfs), .tbe(tbe),
        .underflow(underflow), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Feeder: for each planned slot, write now and queue the expectation,
    // then wait until that slot has taken the buffer.
    task automatic feed();
        foreach (plan_q[i]) begin
            exp_q.push_back(plan_q[i]);
            if (plan_q[i].kind != 0) begin
                wdata   = plan_q[i].word;
                wr_data = (plan_q[i].kind == 1);
                wr_idle = (plan_q[i].kind == 2);
                @(negedge clk);
                wr_data = 1'b0;
                wr_idle = 1'b0;
                chk("R4 tbe after write", tbe, 0);
                chk("R9 irq after write", irq, 0);
            end
            @(slot_ev);
        end
    endtask

    // Bit driver and monitor for a run of frames.
    task automatic run_frames(input int nframes);
        int    wl, ns, oe_cnt;
        logic [15:0] got, expw;
        item_t it;
        wl = cfg_wlen16 ? 16 : 8;
        ns = cfg_network ? int'(cfg_slots_m1) + 1 : 1;
        oe_cnt = 0;
        got = '0;
        repeat (3) @(negedge clk);
        for (int f = 0; f < nframes; f++) begin
            for (int b = 0; b < ns * wl + GAP_BITS; b++) begin
                @(negedge clk);
                bit_en = 1'b1;
                fsync  = (b == 0);
                @(negedge clk);
                bit_en = 1'b0;
                fsync  = 1'b0;
                if (b < ns * wl) begin
                    if (b % wl == 0) begin
                        oe_cnt = 0;
                        got    = '0;
                        chk("R6 tfs in slot", tfs, (b == 0));
                        chk("R4 tbe after transfer", tbe, 1);
                        chk("R9 irq with buffer empty", irq, irq_en);
                        if (exp_q.size() > 0)
                            chk("R8 underflow at slot start", underflow, (exp_q[0].kind == 0));
                    end
                    got = {got[14:0], sd_out};
                    oe_cnt += int'(sd_oe);
                    if (b % wl == wl - 1) begin
                        if (exp_q.size() == 0) begin
                            chk("R5 scoreboard not empty", 0, 1);
                        end else begin
                            it = exp_q.pop_front();
                            if (it.kind == 1) begin
                                expw = (wl == 8) ? {8'd0, it.word[7:0]} : it.word;
                                chk("R2 data slot drive count", oe_cnt, wl);
                                chk("R5 R2 slot word", got, expw);
                            end else if (it.kind == 2) begin
                                chk("R7 idle slot silent", oe_cnt, 0);
                            end else begin
                                chk("R8 underrun slot silent", oe_cnt, 0);
                            end
                        end
                    end
                    if (b % wl == 0) -> slot_ev;
                end else begin
                    chk("R3 no drive between frames", sd_oe, 0);
                end
                repeat (BIT_DIV - 2) @(negedge clk);
            end
        end
    endtask

    task automatic add(input int kind, input logic [15:0] word);
        item_t it;
        it.kind = kind;
        it.word = word;
        plan_q.push_back(it);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tbe reset", tbe, 1);
        chk("R1 tfs reset", tfs, 0);
        chk("R1 underflow reset", underflow, 0);
        chk("R1 sd_oe reset", sd_oe, 0);
        chk("R1 irq reset", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R9 irq enabled while empty", irq, 1);

        // Single-slot frames, 8-bit words with junk upper bytes.
        cfg_network = 1'b0;
        cfg_wlen16  = 1'b0;
        plan_q.delete();
        add(1, 16'h5AA5);
        add(1, 16'hFF3C);
        add(2, 16'h0000);
        add(0, 16'h0000);
        add(1, 16'h0081);
        fork
            run_frames(5);
            feed();
        join

        // Multi-slot frames, 4 slots of 16 bits.
        cfg_network  = 1'b1;
        cfg_wlen16   = 1'b1;
        cfg_slots_m1 = 4'd3;
        plan_q.delete();
        add(1, 16'hBEEF); add(1, 16'h1234); add(0, 16'h0000); add(2, 16'h0000);
        add(1, 16'h8001); add(2, 16'h0000); add(1, 16'h7FFE); add(0, 16'h0000);
        fork
            run_frames(2);
            feed();
        join

        // Full 16-slot frame of 8-bit words, one underrun in the middle.
        cfg_wlen16   = 1'b0;
        cfg_slots_m1 = 4'd15;
        irq_en       = 1'b0;
        plan_q.delete();
        for (int i = 0; i < 16; i++) begin
            if (i == 7) add(0, 16'h0000);
            else        add(1, 16'(i * 37 + 16'hA503));
        end
        fork
            run_frames(1);
            feed();
        join
        chk("R5 scoreboard drained", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule